// File: doc/BRIEF.md
# Flash Cache-Program Sequencer

This block is the host side of a multi-page write into a NAND flash device using the device's cache program flow. A client hands it a starting row and a page count. The block then frames every page on the flash bus as a setup command, a set of address bytes and one page of data bytes. The data bytes come from a byte stream with a valid/ready handshake. Each page is closed with a confirm command, and the block waits on the device's ready line before it starts the next page.

Two endings are supported. In the first, the last page is closed with the page-program confirm. In the second, it is closed with the cache confirm. Either way the block then issues a status read and repeats it until the status shows that internal programming is complete. The error bits of that final status word become the run's result.

Requests that the device cannot accept are refused before any bus cycle is driven. Such a request has a page count of zero, a page count above the per-run limit, or a page range that would leave one erase block. A programmable limit on how long the ready line may stay busy ends a stuck run with an error.

Top module: `nand_cache_prog_seq`

## Requirements
- R1: A request with a count of 0, a count above MAX_PAGES, or with (row mod BLK_PAGES) + count > BLK_PAGES raises err_reject and pulses done, and drives no bus strobe.
- R2: Each page starts with command byte 80h (cmd_latch high), followed by ADDR_CYC address bytes (addr_latch high). The first two address bytes are 00h (column). The rest carry the row, least significant byte first.
- R3: Each page carries exactly PAGE_BYTES data bytes (both latches low). They are taken in order from the stream, one per valid/ready handshake.
- R4: Every page except the last is confirmed with 15h. The next 80h is not issued before flash_ready has returned high.
- R5: The last page is confirmed with 10h when end_cache is 0, and with 15h when end_cache is 1.
- R6: The row sent for page i of a run is the start row plus i.
- R7: After the last page reports ready, the block writes command 70h once, then repeats status reads until bit 5 of the status byte reads 1. It makes no further bus writes during the polling.
- R8: On a completed run, err_program equals bit 0 OR bit 1 of the final status byte.
- R9: If flash_ready stays low for more than timeout_lim sampled cycles, or polling exceeds timeout_lim reads, the run ends with err_timeout set and done pulsed.
- R10: done is a one-cycle pulse. req_ready is high only when the block is idle.
- R11: A write strobe or read strobe is low for STROBE cycles and then high for one cycle. The two strobes are never low together, and cmd_latch and addr_latch are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a run |
| req_ready | output | 1 | Idle, request accepted |
| req_row | input | ROW_W | First row address |
| req_count | input | CNT_W | Number of pages |
| end_cache | input | 1 | 1: last page closed with 15h, 0: with 10h |
| timeout_lim | input | TMO_W | Busy/poll limit |
| din_valid | input | 1 | Stream byte valid |
| din_ready | output | 1 | Stream byte taken |
| din_data | input | 8 | Stream byte |
| bus_out | output | 8 | Flash I/O output byte |
| bus_oe | output | 1 | Flash I/O output enable |
| bus_in | input | 8 | Flash I/O input byte (status) |
| cmd_latch | output | 1 | Command latch enable |
| addr_latch | output | 1 | Address latch enable |
| wr_strobe_n | output | 1 | Write strobe, active low |
| rd_strobe_n | output | 1 | Read strobe, active low |
| flash_ready | input | 1 | Device ready (1) / busy (0) |
| done | output | 1 | Run finished pulse |
| err_reject | output | 1 | Last request refused |
| err_timeout | output | 1 | Last run timed out |
| err_program | output | 1 | Last run reported a program failure |

## Verification
The bench sweeps several start rows, including one at the last page of a block, against every page count from 0 to one past the limit in both ending modes. This catches an off-by-one in the block-crossing test: such a design would either refuse a run that ends exactly at a block edge or write past the edge. A device model counts strobes on refused requests, so a design that emits even the setup command before refusing is caught. The model holds status bit 5 low for several reads in cache-ending runs. A design that stops after one read, or that confuses the two final confirm codes, shows a wrong read count or a wrong last confirm. Stuck-busy runs check that the timeout ends the run instead of hanging or moving on to the next page.

// File: rtl/nand_cache_prog_seq.sv
module nand_cache_prog_seq #(
  parameter int ROW_W      = 24,
  parameter int ADDR_CYC   = 5,
  parameter int PAGE_BYTES = 2112,
  parameter int MAX_PAGES  = 64,
  parameter int BLK_PAGES  = 64,
  parameter int CNT_W      = 8,
  parameter int STROBE     = 2,
  parameter int TWB        = 4,
  parameter int TMO_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [CNT_W-1:0] req_count,
  input  logic             end_cache,
  input  logic [TMO_W-1:0] timeout_lim,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  output logic [7:0]       bus_out,
  output logic             bus_oe,
  input  logic [7:0]       bus_in,
  output logic             cmd_latch,
  output logic             addr_latch,
  output logic             wr_strobe_n,
  output logic             rd_strobe_n,
  input  logic             flash_ready,
  output logic             done,
  output logic             err_reject,
  output logic             err_timeout,
  output logic             err_program
);
  localparam int PH_W  = $clog2(STROBE + 1);
  localparam int IDX_W = $clog2(PAGE_BYTES + ADDR_CYC + TWB + 1);
  localparam int BLK_W = $clog2(BLK_PAGES);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_DATA, S_CONF, S_WB, S_BUSY, S_STC, S_RD
  } st_t;

  st_t              st;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic [ROW_W-1:0] row;
  logic [CNT_W-1:0] left;
  logic             mode, have;
  logic [TMO_W-1:0] lim, tcnt;
  logic [7:0]       dbyte, stat;

  logic [CNT_W:0]      span;
  logic                bad, wr_st, act, low, step, last;
  logic [ROW_W+15:0]   abus;

  assign span = (CNT_W+1)'(req_row[BLK_W-1:0]) + (CNT_W+1)'(req_count);
  assign bad  = (req_count == '0) || (req_count > CNT_W'(MAX_PAGES)) ||
                (span > (CNT_W+1)'(BLK_PAGES));

  assign wr_st = (st == S_CMD) || (st == S_ADDR) || (st == S_CONF) ||
                 (st == S_STC) || (st == S_DATA && have);
  assign act   = wr_st || (st == S_RD);
  assign low   = act && (ph < PH_W'(STROBE));
  assign step  = act && (ph == PH_W'(STROBE));
  assign last  = (left == CNT_W'(1));
  assign abus  = {row, 16'h0000};

  assign req_ready   = (st == S_IDLE);
  assign din_ready   = (st == S_DATA) && !have;
  assign bus_oe      = wr_st;
  assign cmd_latch   = (st == S_CMD) || (st == S_CONF) || (st == S_STC);
  assign addr_latch  = (st == S_ADDR);
  assign wr_strobe_n = !(low && st != S_RD);
  assign rd_strobe_n = !(low && st == S_RD);

  always_comb begin
    case (st)
      S_CMD:   bus_out = 8'h80;
      S_ADDR:  bus_out = abus[int'(idx)*8 +: 8];
      S_DATA:  bus_out = dbyte;
      S_CONF:  bus_out = (last && !mode) ? 8'h10 : 8'h15;
      S_STC:   bus_out = 8'h70;
      default: bus_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; idx <= '0; row <= '0; left <= '0;
      mode <= 1'b0; have <= 1'b0; lim <= '0; tcnt <= '0;
      dbyte <= '0; stat <= '0; done <= 1'b0;
      err_reject <= 1'b0; err_timeout <= 1'b0; err_program <= 1'b0;
    end else begin
      done <= 1'b0;
      if (act) ph <= step ? '0 : ph + PH_W'(1);
      case (st)
        S_IDLE: if (req_valid) begin
          err_reject <= 1'b0; err_timeout <= 1'b0; err_program <= 1'b0;
          if (bad) begin
            err_reject <= 1'b1;
            done       <= 1'b1;
          end else begin
            row  <= req_row;
            left <= req_count;
            mode <= end_cache;
            lim  <= timeout_lim;
            ph   <= '0;
            st   <= S_CMD;
          end
        end
        S_CMD: if (step) begin
          idx <= '0;
          st  <= S_ADDR;
        end
        S_ADDR: if (step) begin
          if (idx == IDX_W'(ADDR_CYC - 1)) begin
            idx <= '0;
            st  <= S_DATA;
          end else idx <= idx + IDX_W'(1);
        end
        S_DATA: begin
          if (!have && din_valid) begin
            dbyte <= din_data;
            have  <= 1'b1;
          end
          if (step) begin
            have <= 1'b0;
            if (idx == IDX_W'(PAGE_BYTES - 1)) begin
              idx <= '0;
              st  <= S_CONF;
            end else idx <= idx + IDX_W'(1);
          end
        end
        S_CONF: if (step) begin
          idx  <= '0;
          tcnt <= '0;
          st   <= S_WB;
        end
        S_WB: begin
          if (idx == IDX_W'(TWB - 1)) st <= S_BUSY;
          else idx <= idx + IDX_W'(1);
        end
        S_BUSY: begin
          if (flash_ready) begin
            tcnt <= '0;
            if (last) st <= S_STC;
            else begin
              left <= left - CNT_W'(1);
              row  <= row + ROW_W'(1);
              st   <= S_CMD;
            end
          end else if (tcnt == lim) begin
            err_timeout <= 1'b1;
            done        <= 1'b1;
            st          <= S_IDLE;
          end else tcnt <= tcnt + TMO_W'(1);
        end
        S_STC: if (step) st <= S_RD;
        S_RD: begin
          if (ph == PH_W'(STROBE - 1)) stat <= bus_in;
          if (step) begin
            if (stat[5]) begin
              err_program <= stat[0] | stat[1];
              done        <= 1'b1;
              st          <= S_IDLE;
            end else if (tcnt == lim) begin
              err_timeout <= 1'b1;
              done        <= 1'b1;
              st          <= S_IDLE;
            end else tcnt <= tcnt + TMO_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_strobe_n && !rd_strobe_n));
  a_r11_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_latch && addr_latch));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_ready_before_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && $past(st) == S_BUSY) |-> $past(flash_ready));
  a_r7_no_write_polling: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD) |-> wr_strobe_n);
endmodule

// File: tb/nand_cache_prog_seq_tb.sv
`timescale 1ns/1ps
module nand_cache_prog_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, end_cache = 1'b0;
  logic [15:0] req_row = '0;
  logic [7:0]  req_count = '0;
  logic [11:0] timeout_lim = '0;
  logic        din_valid, din_ready;
  logic [7:0]  din_data, bus_out, bus_in;
  logic        bus_oe, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, flash_ready;
  logic        done, err_reject, err_timeout, err_program;

  nand_cache_prog_seq #(.ROW_W(16), .ADDR_CYC(4), .PAGE_BYTES(4), .MAX_PAGES(8),
    .BLK_PAGES(8), .CNT_W(8), .STROBE(1), .TWB(2), .TMO_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_count(req_count), .end_cache(end_cache),
    .timeout_lim(timeout_lim), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .cmd_latch(cmd_latch), .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n),
    .rd_strobe_n(rd_strobe_n), .flash_ready(flash_ready), .done(done),
    .err_reject(err_reject), .err_timeout(err_timeout), .err_program(err_program));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stream feeder
  logic [7:0] base = '0;
  int fcnt = 0;
  bit feed_en = 1'b1;
  assign din_valid = feed_en;
  assign din_data  = 8'(int'(base) + fcnt);
  always @(posedge clk) if (din_valid && din_ready) fcnt <= fcnt + 1;

  // device model
  bit rb = 1'b1, stuck = 1'b0, sr0 = 1'b0, sr1 = 1'b0, pmode = 1'b0;
  bit we_q = 1'b1, re_q = 1'b1;
  int busy = 0, polls = 0, nwe = 0, npage = 0, colnz = 0, derr = 0, mdcnt = 0;
  int n70 = 0, nrd = 0, bad_order = 0, acnt = 0;
  logic [7:0]  abuf [4];
  logic [7:0]  conf [16];
  logic [15:0] prow [16];
  assign flash_ready = rb;
  assign bus_in = {1'b1, 1'b1, (polls == 0), 3'b000, sr1, sr0};

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe_n && !we_q) begin
        nwe++;
        if (cmd_latch) begin
          case (bus_out)
            8'h80: begin if (!rb) bad_order++; acnt = 0; end
            8'h10, 8'h15: begin
              if (npage < 16) begin conf[npage] = bus_out; prow[npage] = {abuf[3], abuf[2]}; end
              if (abuf[0] != 0 || abuf[1] != 0) colnz++;
              npage++; rb = 1'b0; busy = 6;
            end
            8'h70: begin n70++; polls = pmode ? 3 : 0; end
            default: derr++;
          endcase
        end else if (addr_latch) begin
          if (acnt < 4) abuf[acnt] = bus_out;
          acnt++;
        end else begin
          if (bus_out != 8'(int'(base) + mdcnt)) derr++;
          mdcnt++;
        end
      end
      if (rd_strobe_n && !re_q) begin nrd++; if (polls > 0) polls--; end
      if (busy > 0) begin busy--; if (busy == 0 && !stuck) rb = 1'b1; end
    end
    we_q = wr_strobe_n; re_q = rd_strobe_n;
  end

  task automatic run(input int row, input int cnt, input bit mode, input bit s0,
                     input bit s1, input bit stk, input int lim);
    bit got, ok_req;
    @(negedge clk);
    nwe = 0; npage = 0; colnz = 0; derr = 0; mdcnt = 0; n70 = 0; nrd = 0;
    bad_order = 0; fcnt = 0; base = 8'(row * 7 + cnt);
    sr0 = s0; sr1 = s1; stuck = stk; pmode = mode;
    req_row = 16'(row); req_count = 8'(cnt); end_cache = mode;
    timeout_lim = 12'(lim); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 5000 && !got; i++) begin
      if (done) got = 1'b1; else @(negedge clk);
    end
    chk(got, "R10 done seen", int'(got), 1);
    ok_req = cnt >= 1 && cnt <= 8 && ((row % 8) + cnt <= 8);
    if (!ok_req) begin
      chk(err_reject == 1'b1, "R1 reject flag", int'(err_reject), 1);
      chk(nwe == 0, "R1 no bus writes", nwe, 0);
      chk(nrd == 0, "R1 no bus reads", nrd, 0);
    end else if (stk) begin
      chk(err_timeout == 1'b1, "R9 timeout flag", int'(err_timeout), 1);
      chk(npage == 1 && n70 == 0, "R9 run stopped", npage, 1);
      chk(err_reject == 1'b0, "R9 no reject", int'(err_reject), 0);
    end else begin
      chk(err_reject == 1'b0 && err_timeout == 1'b0, "R1 accepted clean",
          int'({err_reject, err_timeout}), 0);
      chk(npage == cnt, "R2 page count", npage, cnt);
      chk(colnz == 0, "R2 column zero", colnz, 0);
      chk(mdcnt == cnt * 4 && fcnt == cnt * 4, "R3 data byte count", mdcnt, cnt * 4);
      chk(derr == 0, "R3 data order", derr, 0);
      chk(bad_order == 0, "R4 wait ready", bad_order, 0);
      for (int i = 0; i < cnt - 1; i++)
        chk(conf[i] == 8'h15, "R4 cache confirm", int'(conf[i]), 'h15);
      chk(conf[cnt-1] == (mode ? 8'h15 : 8'h10), "R5 last confirm",
          int'(conf[cnt-1]), mode ? 'h15 : 'h10);
      for (int i = 0; i < cnt; i++)
        chk(prow[i] == 16'(row + i), "R6 row", int'(prow[i]), row + i);
      chk(n70 == 1, "R7 status command", n70, 1);
      chk(nrd == (mode ? 4 : 1), "R7 poll reads", nrd, mode ? 4 : 1);
      chk(err_program == (s0 | s1), "R8 result", int'(err_program), int'(s0 | s1));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    chk(req_ready == 1'b1, "R10 idle ready", int'(req_ready), 1);
    stuck = 1'b0; rb = 1'b1; busy = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rows [5] = '{0, 3, 7, 13, 'h12F8};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R10 reset idle", int'(req_ready), 1);
    chk(wr_strobe_n && rd_strobe_n, "R11 reset strobes", int'({wr_strobe_n, rd_strobe_n}), 3);
    chk(!cmd_latch && !addr_latch && !din_ready, "R11 reset latches",
        int'({cmd_latch, addr_latch, din_ready}), 0);
    rst_n = 1'b1;
    foreach (rows[k])
      for (int c = 0; c <= 9; c++)
        for (int m = 0; m < 2; m++)
          run(rows[k], c, m[0], (c == 2) && m == 1, (c == 5) && m == 0, 1'b0, 1000);
    run(8, 3, 1'b0, 1'b0, 1'b0, 1'b1, 40);
    run(8, 3, 1'b1, 1'b0, 1'b0, 1'b1, 40);
    run(16, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule